// File: doc/BRIEF.md
# Serial EEPROM Slave Model (Three-Wire Command, Four-Wire Link)

This block is a synthesizable model of a small serial EEPROM that holds 16-bit words. A host talks to it over four wires: a select line, a serial clock, a data input and a data output. While select is high, the host shifts in a command one bit per rising serial-clock edge, MSB first. The command is a start bit of 1, a two-bit opcode and a word address, followed by sixteen data bits for the commands that carry data. The block answers reads on the data output. It stores writes into its word array, and it reports programming progress as a ready/busy level.

The serial clock and data lines are sampled by the system clock. A rising edge of the serial clock is found by comparing the line with its value one system cycle earlier, so the host must hold each serial-clock level for at least two system cycles. The address width is set by a parameter to 6 or 8 bits. The programming time is a count of system clock cycles.

Top module: `ser_eeprom`

## Requirements
- R1: After reset the array holds 16'hFFFF in every word, programming is disabled, and the data output is low.
- R2: Opcode 10 (read) presents a single 0 on the data output once the last address bit is taken. Each following rising serial-clock edge then presents the next bit of the addressed word, MSB first.
- R3: Opcode 01 (write), followed by the address and 16 data bits, stores the data in the addressed word when programming is enabled.
- R4: Opcode 11 (erase) sets the addressed word to 16'hFFFF when programming is enabled.
- R5: Opcode 00 is decoded by the two most significant address bits. With 11 programming is enabled, and with 00 it is disabled. While programming is disabled, write, erase, erase-all and write-all leave the array unchanged.
- R6: Under opcode 00, sub-code 10 sets every word to 16'hFFFF, and sub-code 01 followed by 16 data bits writes that value into every word, when programming is enabled.
- R7: Driving select low abandons any command in progress. Nothing is stored, and the next command is decoded from a fresh start bit.
- R8: Zeros clocked in while select is high and before the start bit are ignored.
- R9: After a command that programs the array, once select is lowered and raised again, the data output reads 0 while programming is in progress. It reads 1 once BUSY_CYCLES system cycles have passed since the store.
- R10: A command shifted in while programming is in progress has no effect on the array.
- R11: The data output is low whenever select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Chip select, active high |
| sclk | input | 1 | Serial clock from the host |
| sdin | input | 1 | Serial command and data input |
| sdout | output | 1 | Serial read data and ready/busy status |

## Verification
A wrong enable flag or a wrong store would show only when that word is read back. A wrong sub-code decode could therefore stay hidden until a later read, so every programming step is followed by a read of the words it should have changed and of words it should not have changed. A decoder that has lost track of the command shows on the data output at once, because the first sampled bit of a read is the dummy zero. A wrong busy count shows in the status poll within the programming window: either a 1 appears too early, or the 1 never arrives.

// File: rtl/ser_eeprom_pkg.sv
package ser_eeprom_pkg;

    localparam int WORD_W  = 16;
    localparam int MAX_AW  = 8;
    localparam int CNT_W   = 5;
    localparam logic [WORD_W-1:0] BLANK_WORD = '1;

    typedef enum logic [1:0] {
        OPC_EXT   = 2'b00,
        OPC_WRITE = 2'b01,
        OPC_READ  = 2'b10,
        OPC_ERASE = 2'b11
    } opcode_e;

    typedef enum logic [1:0] {
        SUB_LOCK  = 2'b00,
        SUB_FILL  = 2'b01,
        SUB_CLEAR = 2'b10,
        SUB_OPEN  = 2'b11
    } subcode_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_OPC,
        PH_ADR,
        PH_DAT,
        PH_OUT,
        PH_HOLD
    } phase_e;

    typedef struct packed {
        logic              every;
        logic [MAX_AW-1:0] addr;
        logic [WORD_W-1:0] data;
    } store_req_t;

    function automatic logic last_bit(input logic [CNT_W-1:0] cnt, input int n);
        return cnt == CNT_W'(n - 1);
    endfunction

endpackage

// File: rtl/ser_eeprom_edge.sv
module ser_eeprom_edge (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    output logic rise
);
    logic line_q;

    always_ff @(posedge clk) begin
        if (rst) line_q <= 1'b0;
        else     line_q <= line_in;
    end

    assign rise = line_in & ~line_q;
endmodule

// File: rtl/ser_eeprom_array.sv
module ser_eeprom_array
    import ser_eeprom_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              st_we,
    input  store_req_t        st_req,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= BLANK_WORD;
        end else if (st_we) begin
            if (st_req.every) begin
                for (int i = 0; i < DEPTH; i++) cells[i] <= st_req.data;
            end else begin
                cells[st_req.addr[ADDR_W-1:0]] <= st_req.data;
            end
        end
    end

    assign rd_data = cells[rd_addr];
endmodule

// File: rtl/ser_eeprom_timer.sv
module ser_eeprom_timer #(
    parameter int BUSY_CYCLES = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    localparam int TW = $clog2(BUSY_CYCLES + 1);

    logic [TW-1:0] left;

    always_ff @(posedge clk) begin
        if (rst)              left <= '0;
        else if (start)       left <= TW'(BUSY_CYCLES);
        else if (left != '0)  left <= left - 1'b1;
    end

    assign busy = left != '0;
endmodule

// File: rtl/ser_eeprom_ctrl.sv
module ser_eeprom_ctrl
    import ser_eeprom_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              sdin,
    input  logic              sk_rise,
    input  logic              busy,
    input  logic [WORD_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              st_we,
    output store_req_t        st_req,
    output phase_e            phase,
    output logic              wen,
    output logic              sdout
);
    logic [CNT_W-1:0]  cnt;
    logic [1:0]        opc;
    logic [ADDR_W-1:0] adr;
    logic [WORD_W-1:0] dat;
    logic [WORD_W:0]   out_sr;
    logic              show_stat;
    logic [ADDR_W-1:0] adr_nx;
    logic [WORD_W-1:0] dat_nx;
    subcode_e          sub_nx;

    assign adr_nx  = {adr[ADDR_W-2:0], sdin};
    assign dat_nx  = {dat[WORD_W-2:0], sdin};
    assign sub_nx  = subcode_e'(adr_nx[ADDR_W-1 -: 2]);
    assign rd_addr = adr_nx;

    always_ff @(posedge clk) begin
        st_we <= 1'b0;
        if (rst) begin
            phase     <= PH_IDLE;
            cnt       <= '0;
            opc       <= '0;
            adr       <= '0;
            dat       <= '0;
            out_sr    <= '0;
            wen       <= 1'b0;
            show_stat <= 1'b0;
            st_req    <= '0;
        end else if (!sel) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else if (sk_rise) begin
            case (phase)
                PH_IDLE: begin
                    if (sdin && !busy) begin
                        phase     <= PH_OPC;
                        cnt       <= '0;
                        show_stat <= 1'b0;
                    end
                end
                PH_OPC: begin
                    opc <= {opc[0], sdin};
                    if (last_bit(cnt, 2)) begin
                        phase <= PH_ADR;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_ADR: begin
                    adr <= adr_nx;
                    cnt <= cnt + 1'b1;
                    if (last_bit(cnt, ADDR_W)) begin
                        cnt   <= '0;
                        phase <= PH_HOLD;
                        case (opcode_e'(opc))
                            OPC_READ: begin
                                out_sr <= {1'b0, rd_data};
                                phase  <= PH_OUT;
                            end
                            OPC_WRITE: phase <= PH_DAT;
                            OPC_ERASE: begin
                                if (wen) begin
                                    st_we     <= 1'b1;
                                    show_stat <= 1'b1;
                                    st_req    <= '{every: 1'b0, addr: MAX_AW'(adr_nx), data: BLANK_WORD};
                                end
                            end
                            default: begin
                                case (sub_nx)
                                    SUB_OPEN:  wen <= 1'b1;
                                    SUB_LOCK:  wen <= 1'b0;
                                    SUB_FILL:  phase <= PH_DAT;
                                    default: begin
                                        if (wen) begin
                                            st_we     <= 1'b1;
                                            show_stat <= 1'b1;
                                            st_req    <= '{every: 1'b1, addr: '0, data: BLANK_WORD};
                                        end
                                    end
                                endcase
                            end
                        endcase
                    end
                end
                PH_DAT: begin
                    dat <= dat_nx;
                    cnt <= cnt + 1'b1;
                    if (last_bit(cnt, WORD_W)) begin
                        phase <= PH_HOLD;
                        if (wen) begin
                            st_we     <= 1'b1;
                            show_stat <= 1'b1;
                            st_req    <= '{every: (opc == OPC_EXT), addr: MAX_AW'(adr), data: dat_nx};
                        end
                    end
                end
                PH_OUT: begin
                    if (last_bit(cnt, WORD_W + 1)) begin
                        phase <= PH_HOLD;
                    end else begin
                        out_sr <= {out_sr[WORD_W-1:0], 1'b0};
                        cnt    <= cnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        sdout = 1'b0;
        if (sel) begin
            if (phase == PH_OUT)                    sdout = out_sr[WORD_W];
            else if (phase == PH_IDLE && show_stat) sdout = ~busy;
        end
    end
endmodule

// File: rtl/ser_eeprom.sv
module ser_eeprom
    import ser_eeprom_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int BUSY_CYCLES = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic sel,
    input  logic sclk,
    input  logic sdin,
    output logic sdout
);
    logic              sk_rise;
    logic              busy;
    logic              st_we;
    logic              wen;
    store_req_t        st_req;
    phase_e            phase;
    logic [ADDR_W-1:0] rd_addr;
    logic [WORD_W-1:0] rd_data;

    ser_eeprom_edge u_edge (
        .clk(clk), .rst(rst), .line_in(sclk), .rise(sk_rise)
    );

    ser_eeprom_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst(rst), .sel(sel), .sdin(sdin), .sk_rise(sk_rise),
        .busy(busy), .rd_data(rd_data), .rd_addr(rd_addr), .st_we(st_we),
        .st_req(st_req), .phase(phase), .wen(wen), .sdout(sdout)
    );

    ser_eeprom_array #(.ADDR_W(ADDR_W)) u_array (
        .clk(clk), .rst(rst), .st_we(st_we), .st_req(st_req),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    ser_eeprom_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
        .clk(clk), .rst(rst), .start(st_we), .busy(busy)
    );
endmodule

// File: rtl/ser_eeprom_chk.sv
module ser_eeprom_chk
    import ser_eeprom_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   sel,
    input logic   sdout,
    input logic   st_we,
    input logic   wen,
    input logic   busy,
    input phase_e phase
);
    // R1
    reset_locked_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !wen);

    // R5
    store_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        st_we |-> wen);

    // R9
    store_starts_busy_chk: assert property (@(posedge clk) disable iff (rst)
        st_we |=> busy);

    // R10
    no_store_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !st_we);

    // R7
    deselect_resets_chk: assert property (@(posedge clk) disable iff (rst)
        !sel |=> phase == PH_IDLE);

    // R11
    quiet_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !sel |-> !sdout);
endmodule

bind ser_eeprom ser_eeprom_chk u_chk (
    .clk(clk), .rst(rst), .sel(sel), .sdout(sdout), .st_we(st_we),
    .wen(wen), .busy(busy), .phase(phase)
);

// File: tb/sim_ser_eeprom.sv
module sim_ser_eeprom;
    localparam int AW   = 6;
    localparam int BUSY = 300;

    logic clk = 1'b0, rst = 1'b1, sel = 1'b0, sclk = 1'b0, sdin = 1'b0;
    logic sdout;
    int total = 0, bad = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic [15:0] rd_word = '0;
    logic        rd_valid = 1'b0;
    logic        finished = 1'b0;

    always #5 clk = ~clk;

    ser_eeprom #(.ADDR_W(AW), .BUSY_CYCLES(BUSY)) u0 (
        .clk(clk), .rst(rst), .sel(sel), .sclk(sclk), .sdin(sdin), .sdout(sdout)
    );

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: compares each assembled read word with the oldest expectation
    always @(posedge clk) begin
        if (rd_valid) begin
            logic [15:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            total++;
            if (rd_word !== e) begin
                bad++;
                $display("FAIL %s actual=%h expected=%h", t, rd_word, e);
            end
        end
    end

    task automatic sbit(input logic b, output logic samp);
        @(negedge clk); sclk = 1'b0; sdin = b;
        repeat (3) @(negedge clk);
        samp = sdout;
        sclk = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic send(input int v, input int n);
        logic s;
        for (int i = n - 1; i >= 0; i--) sbit(v[i], s);
    endtask

    task automatic sel_up;
        @(negedge clk); sel = 1'b1; sclk = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic sel_dn;
        @(negedge clk); sel = 1'b0; sclk = 1'b0; sdin = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic cmd_write(input int a, input int d);
        sel_up; send(3'b101, 3); send(a, AW); send(d, 16); sel_dn;
    endtask

    task automatic cmd_erase(input int a);
        sel_up; send(3'b111, 3); send(a, AW); sel_dn;
    endtask

    task automatic cmd_ext(input int sub);
        sel_up; send(3'b100, 3); send(sub << (AW - 2), AW); sel_dn;
    endtask

    task automatic cmd_fill(input int d);
        sel_up; send(3'b100, 3); send(1 << (AW - 2), AW); send(d, 16); sel_dn;
    endtask

    // driver: queues the expected word, then clocks the read out
    task automatic read_word(input int a, input logic [15:0] exp, input string tag, input int lead);
        logic s;
        logic [15:0] w;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        sel_up;
        send(0, lead);
        send(3'b110, 3);
        send(a, AW);
        sbit(1'b0, s);
        check(s === 1'b0, "R2 dummy zero", s, 0);
        for (int i = 0; i < 16; i++) begin
            sbit(1'b0, s);
            w = {w[14:0], s};
        end
        @(negedge clk); rd_word = w; rd_valid = 1'b1;
        @(negedge clk); rd_valid = 1'b0;
        sel_dn;
    endtask

    task automatic wait_ready(input logic timed);
        int n;
        n = 0;
        sel_up;
        check(sdout === 1'b0, "R9 busy after store", sdout, 0);
        while (sdout !== 1'b1 && n < BUSY + 100) begin
            @(negedge clk);
            n++;
        end
        check(sdout === 1'b1, "R9 ready", sdout, 1);
        if (timed) check(n >= BUSY - 30 && n <= BUSY, "R9 busy length", n, BUSY);
        sel_dn;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic s;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(sdout === 1'b0, "R1 output low after reset", sdout, 0);
        read_word(0, 16'hFFFF, "R1 blank word 0", 0);
        read_word(63, 16'hFFFF, "R1 blank word 63", 0);

        // R5: writing while locked has no effect
        cmd_write(3, 16'h1234);
        read_word(3, 16'hFFFF, "R5 locked write ignored", 0);

        // R5 open, R3 write
        cmd_ext(3);
        cmd_write(3, 16'hA5C3);
        wait_ready(1'b1);
        read_word(3, 16'hA5C3, "R3 write word 3", 0);
        cmd_write(63, 16'h8001);
        wait_ready(1'b0);
        read_word(63, 16'h8001, "R3 write word 63", 0);
        read_word(4, 16'hFFFF, "R3 neighbour untouched", 0);

        // R4 erase
        cmd_erase(3);
        wait_ready(1'b0);
        read_word(3, 16'hFFFF, "R4 erase word 3", 0);

        // R10: second write during busy is ignored
        cmd_write(10, 16'h1111);
        cmd_write(10, 16'h2222);
        wait_ready(1'b0);
        read_word(10, 16'h1111, "R10 write during busy ignored", 0);

        // R7: abandoned write
        sel_up; send(3'b101, 3); send(9, AW); send(8'hC3, 8); sel_dn;
        read_word(9, 16'hFFFF, "R7 abandoned write", 0);
        // R7 / R11: abandoned read, output low when deselected
        sel_up; send(3'b110, 3); send(63, AW); sbit(1'b0, s); sbit(1'b0, s); sel_dn;
        check(sdout === 1'b0, "R11 output low when deselected", sdout, 0);
        read_word(63, 16'h8001, "R7 fresh command after abort", 0);

        // R8 leading zeros
        read_word(63, 16'h8001, "R8 leading zeros", 3);

        // R6 fill and clear
        cmd_fill(16'h5A5A);
        wait_ready(1'b0);
        read_word(0, 16'h5A5A, "R6 fill word 0", 0);
        read_word(20, 16'h5A5A, "R6 fill word 20", 0);
        read_word(63, 16'h5A5A, "R6 fill word 63", 0);
        cmd_ext(2);
        wait_ready(1'b0);
        read_word(20, 16'hFFFF, "R6 clear word 20", 0);

        // R5 lock again
        cmd_write(7, 16'h0F0F);
        wait_ready(1'b0);
        cmd_ext(0);
        cmd_write(7, 16'h0000);
        cmd_erase(7);
        read_word(7, 16'h0F0F, "R5 locked write/erase ignored", 0);
        cmd_ext(2);
        read_word(7, 16'h0F0F, "R5 locked clear ignored", 0);

        repeat (4) @(negedge clk);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule